// File: doc/BRIEF.md
# SMBus Bus Timeout Monitor

This block watches the SCL and SDA lines of an SMBus segment without ever driving them. Both lines pass through a synchronizer and a glitch filter. A small state machine then follows the bus: it finds START and STOP conditions, counts the SCL pulses of each byte frame and marks the acknowledge clock. Alongside it, three saturating accumulators count clock-low time in prescaler ticks, each against its own limit and each with its own restart points.

The first accumulator measures one unbroken SCL-low period. The second adds up every SCL-low tick from a START to the matching STOP; this is the budget for slave clock extension. The third adds up SCL-low ticks only within one byte segment, which runs from START to the first acknowledge clock, from one acknowledge clock to the next, or from the last acknowledge clock to STOP; this is the budget for master clock extension. A monitor that only listens cannot tell which device holds SCL low, so both cumulative budgets count all SCL-low time inside a transfer.

A START or STOP that does not sit on the first SCL pulse of a frame is a bus error. Each error kind sets its own sticky flag, and the interrupt output stays high while any flag is set. Software clears flags by pulsing the matching clear bits. Any error event returns the state machine to idle and zeroes all accumulators and the bit counter, so the next START begins a clean measurement.

The controller has four states. ST_IDLE is the free bus, and a START takes it to ST_HOLD. ST_HOLD is SCL high just after a START; an SCL fall takes it to ST_DATA with the bit count at 0, and a START or STOP there is an error. ST_DATA counts SCL rising edges. A START while the count is 1 goes back to ST_HOLD (repeated start). A STOP while the count is 1 goes to ST_IDLE. Any other START or STOP in ST_DATA is an error. The ninth rising edge goes to ST_ACK and marks the acknowledge clock. ST_ACK lasts while SCL is high in the acknowledge slot; an SCL fall returns to ST_DATA with the count at 0, and any START or STOP there is an error. Every error event forces ST_IDLE.

Top module: `smbus_tmo_mon`

## Requirements
- R1: When filtered SCL stays low for more than TLOW_TICKS prescaler ticks in a row, flags_o bit 0 is set; a low period at or below the limit sets nothing.
- R2: SCL-low ticks summed from START to STOP, not restarted at acknowledge clocks, set flags_o bit 1 when the total exceeds XFER_TICKS.
- R3: SCL-low ticks summed within one byte segment set flags_o bit 2 when they exceed SEG_TICKS; the sum restarts at START, at STOP and at each ninth SCL rising edge.
- R4: A START is SDA falling while SCL is high, and a STOP is SDA rising while SCL is high. Either one is legal only on the first SCL pulse after a START or after the ninth pulse of a frame, and a START is also legal on an idle bus. Anywhere else it sets flags_o bit 3.
- R5: A STOP seen while the bus is idle sets no flag.
- R6: Each flag stays set until its own bit of flag_clr_i is pulsed high; clearing one bit leaves the other flags unchanged.
- R7: irq_o is high exactly while at least one flag is set.
- R8: After any error event the controller is idle with a zero bit count and all accumulators are cleared, so a following legal transfer sets no flag.
- R9: After reset all flags and irq_o are low.
- R10: A change on SCL or SDA that lasts fewer than FILT_LEN system-clock cycles is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| flag_clr_i | input | 4 | Write-one-to-clear pulses, one per flag |
| flags_o | output | 4 | Sticky flags: bit 0 low timeout, bit 1 transfer extension, bit 2 segment extension, bit 3 bus error |
| irq_o | output | 1 | High while any flag is set |

## Verification
The assertions rely on three properties of the inputs. SCL and SDA never change together. Every intended level lasts longer than the filter window. SDA changes during SCL-low, except for the START and STOP conditions that the bench places on purpose. The bench meets these by driving all bit data halfway through the SCL-low phase and keeping every phase at least four cycles long. Low-time limits are tested only with a margin of at least three ticks on either side, so that the tick phase and the filter delay cannot flip an expected result. The random transfers draw their low periods from a range that keeps both cumulative budgets well below their limits.

// File: rtl/smbus_tmo_pkg.sv
package smbus_tmo_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_DATA = 2'd2,
        ST_ACK  = 2'd3
    } mon_state_e;

    localparam int unsigned NUM_FLAGS  = 4;
    localparam int unsigned NUM_ACC    = 3;
    localparam int unsigned FLG_TLOW   = 0;
    localparam int unsigned FLG_XFER   = 1;
    localparam int unsigned FLG_SEG    = 2;
    localparam int unsigned FLG_BERR   = 3;
    localparam int unsigned FRAME_BITS = 9;

endpackage

// File: rtl/smbus_line_filt.sv
module smbus_line_filt #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic chg_o
);
    localparam int unsigned RW = (FILT_LEN > 1) ? $clog2(FILT_LEN) : 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [RW-1:0]          run_q;
    logic                   raw;

    assign raw = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q  <= '1;
            run_q   <= '0;
            level_o <= 1'b1;
            chg_o   <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
            chg_o  <= 1'b0;
            if (raw == level_o) begin
                run_q <= '0;
            end else if (run_q == RW'(FILT_LEN - 1)) begin
                level_o <= raw;
                chg_o   <= 1'b1;
                run_q   <= '0;
            end else begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/smbus_tick_gen.sv
module smbus_tick_gen #(
    parameter int unsigned PRESCALE = 100
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

    logic [PW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            tick_o <= 1'b0;
        end else if (div_q == PW'(PRESCALE - 1)) begin
            div_q  <= '0;
            tick_o <= 1'b1;
        end else begin
            div_q  <= div_q + 1'b1;
            tick_o <= 1'b0;
        end
    end
endmodule

// File: rtl/smbus_low_acc.sv
module smbus_low_acc #(
    parameter int unsigned LIMIT = 1000,
    parameter int unsigned CW    = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic over_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (inc_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign over_o = (cnt_q > CW'(LIMIT));
endmodule

// File: rtl/smbus_tmo_mon.sv
module smbus_tmo_mon
    import smbus_tmo_pkg::*;
#(
    parameter int unsigned PRESCALE    = 100,
    parameter int unsigned TLOW_TICKS  = 30000,
    parameter int unsigned XFER_TICKS  = 25000,
    parameter int unsigned SEG_TICKS   = 10000,
    parameter int unsigned FILT_LEN    = 4,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    input  logic [NUM_FLAGS-1:0] flag_clr_i,
    output logic [NUM_FLAGS-1:0] flags_o,
    output logic                 irq_o
);
    localparam int unsigned MAX_LIM =
        (TLOW_TICKS > XFER_TICKS) ?
            ((TLOW_TICKS > SEG_TICKS) ? TLOW_TICKS : SEG_TICKS) :
            ((XFER_TICKS > SEG_TICKS) ? XFER_TICKS : SEG_TICKS);
    localparam int unsigned CW  = $clog2(MAX_LIM + 2) + 1;
    localparam int unsigned BCW = $clog2(FRAME_BITS + 1);

    function automatic int unsigned limit_of(input int unsigned idx);
        return (idx == 0) ? TLOW_TICKS : ((idx == 1) ? XFER_TICKS : SEG_TICKS);
    endfunction

    // line conditioning
    logic scl_lvl, scl_chg, sda_lvl, sda_chg;
    logic scl_rise, scl_fall, sda_rise, sda_fall;
    logic tick;

    smbus_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
        .clk(clk), .rst_n(rst_n), .line_i(scl_i), .level_o(scl_lvl), .chg_o(scl_chg)
    );
    smbus_line_filt #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
        .clk(clk), .rst_n(rst_n), .line_i(sda_i), .level_o(sda_lvl), .chg_o(sda_chg)
    );
    smbus_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
        .clk(clk), .rst_n(rst_n), .tick_o(tick)
    );

    assign scl_rise = scl_chg & scl_lvl;
    assign scl_fall = scl_chg & ~scl_lvl;
    assign sda_rise = sda_chg & sda_lvl;
    assign sda_fall = sda_chg & ~sda_lvl;

    logic start_ev, stop_ev, cond_ev;
    assign start_ev = sda_fall & scl_lvl;
    assign stop_ev  = sda_rise & scl_lvl;
    assign cond_ev  = start_ev | stop_ev;

    // controller
    mon_state_e         state, state_nx;
    logic [BCW-1:0]     bit_cnt, bit_cnt_nx;
    logic               berr_ev, ack_clk, err_ev;
    logic [NUM_ACC-1:0] acc_over, acc_inc, acc_clr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
        end else begin
            state   <= state_nx;
            bit_cnt <= bit_cnt_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        bit_cnt_nx = bit_cnt;
        berr_ev    = 1'b0;
        ack_clk    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_ev) begin
                    state_nx   = ST_HOLD;
                    bit_cnt_nx = '0;
                end
            end
            ST_HOLD: begin
                if (cond_ev) begin
                    berr_ev = 1'b1;
                end else if (scl_fall) begin
                    state_nx   = ST_DATA;
                    bit_cnt_nx = '0;
                end
            end
            ST_DATA: begin
                if (cond_ev && (bit_cnt != BCW'(1))) begin
                    berr_ev = 1'b1;
                end else if (start_ev) begin
                    state_nx   = ST_HOLD;
                    bit_cnt_nx = '0;
                end else if (stop_ev) begin
                    state_nx   = ST_IDLE;
                    bit_cnt_nx = '0;
                end else if (scl_rise) begin
                    bit_cnt_nx = bit_cnt + 1'b1;
                    if (bit_cnt == BCW'(FRAME_BITS - 1)) begin
                        state_nx = ST_ACK;
                        ack_clk  = 1'b1;
                    end
                end
            end
            ST_ACK: begin
                if (cond_ev) begin
                    berr_ev = 1'b1;
                end else if (scl_fall) begin
                    state_nx   = ST_DATA;
                    bit_cnt_nx = '0;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
        err_ev = berr_ev | (|acc_over);
        if (err_ev) begin
            state_nx   = ST_IDLE;
            bit_cnt_nx = '0;
        end
    end

    // low-time budgets: 0 continuous, 1 whole transfer, 2 byte segment
    logic tick_low, busy;
    assign tick_low = tick & ~scl_lvl;
    assign busy     = (state != ST_IDLE);

    assign acc_inc[FLG_TLOW] = tick_low;
    assign acc_clr[FLG_TLOW] = scl_lvl | err_ev;
    assign acc_inc[FLG_XFER] = tick_low & busy;
    assign acc_clr[FLG_XFER] = start_ev | stop_ev | err_ev;
    assign acc_inc[FLG_SEG]  = tick_low & busy;
    assign acc_clr[FLG_SEG]  = start_ev | stop_ev | ack_clk | err_ev;

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
        smbus_low_acc #(.LIMIT(limit_of(g)), .CW(CW)) u_acc (
            .clk(clk), .rst_n(rst_n), .clr_i(acc_clr[g]),
            .inc_i(acc_inc[g]), .over_o(acc_over[g])
        );
    end

    // outputs
    logic [NUM_FLAGS-1:0] flag_set, flags_nx;
    assign flag_set = {berr_ev, acc_over};
    assign flags_nx = (flags_o & ~flag_clr_i) | flag_set;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_o <= '0;
            irq_o   <= 1'b0;
        end else begin
            flags_o <= flags_nx;
            irq_o   <= |flags_nx;
        end
    end
endmodule

// File: rtl/smbus_tmo_mon_chk.sv
module smbus_tmo_mon_chk
    import smbus_tmo_pkg::*;
#(
    parameter int unsigned BCW = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_FLAGS-1:0] flags_o,
    input logic [NUM_FLAGS-1:0] flag_clr_i,
    input mon_state_e           state,
    input logic [BCW-1:0]       bit_cnt,
    input logic                 scl_lvl,
    input logic                 sda_edge,
    input logic [NUM_ACC-1:0]   acc_over,
    input logic                 err_ev
);
    // R1
    tlow_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[FLG_TLOW]) |-> ($past(scl_lvl, 2) == 1'b0));

    // R3
    seg_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[FLG_SEG]) |-> ($past(state) != ST_IDLE));

    // R4
    berr_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags_o[FLG_BERR]) |-> $past(sda_edge && scl_lvl));

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(flags_o) & ~$past(flag_clr_i)) & ~flags_o) == '0));

    // R8
    err_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_ev |=> ((state == ST_IDLE) && (bit_cnt == '0)));

    // R8
    over_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_over != '0) |=> (acc_over == '0));
endmodule

bind smbus_tmo_mon smbus_tmo_mon_chk #(.BCW(BCW)) u_chk (
    .clk(clk), .rst_n(rst_n), .flags_o(flags_o), .flag_clr_i(flag_clr_i),
    .state(state), .bit_cnt(bit_cnt), .scl_lvl(scl_lvl),
    .sda_edge(sda_rise | sda_fall), .acc_over(acc_over), .err_ev(err_ev)
);

// File: tb/smbus_tmo_mon_bench.sv
`timescale 1ns/1ps
module smbus_tmo_mon_bench;
    localparam int PRE   = 4;
    localparam int TLOW  = 60;
    localparam int XFER  = 150;
    localparam int SEG   = 40;
    localparam int HIGHC = 8;

    logic       clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda = 1'b1;
    logic [3:0] clr = 4'b0;
    logic [3:0] flags;
    logic       irq;
    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    smbus_tmo_mon #(.PRESCALE(PRE), .TLOW_TICKS(TLOW), .XFER_TICKS(XFER),
                    .SEG_TICKS(SEG), .FILT_LEN(2)) u_smbus_tmo_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda),
        .flag_clr_i(clr), .flags_o(flags), .irq_o(irq));

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got hung run expected finish");
            report();
        end
    end

    function automatic logic [3:0] exp_hold(input int ticks);
        return (ticks > TLOW) ? 4'b0001 : 4'b0000;
    endfunction

    function automatic logic [3:0] exp_xfer(input int nbytes, input int lowc);
        int seg_t;
        seg_t = (9 * lowc) / PRE;
        if (seg_t > SEG) return 4'b0100;
        if (nbytes * seg_t > XFER) return 4'b0010;
        return 4'b0000;
    endfunction

    task automatic bus_start();
        scl = 1'b1; sda = 1'b1; waitc(HIGHC);
        sda = 1'b0; waitc(HIGHC);
    endtask

    task automatic bus_bit(input logic b, input int lowc);
        scl = 1'b0; waitc(lowc / 2);
        sda = b;    waitc(lowc - lowc / 2);
        scl = 1'b1; waitc(HIGHC);
    endtask

    task automatic bus_byte(input logic [7:0] d, input int lowc);
        for (int i = 7; i >= 0; i--) bus_bit(d[i], lowc);
        bus_bit(1'b0, lowc);
    endtask

    task automatic bus_stop(input int lowc);
        scl = 1'b0; waitc(lowc / 2);
        sda = 1'b0; waitc(lowc - lowc / 2);
        scl = 1'b1; waitc(HIGHC);
        sda = 1'b1; waitc(HIGHC);
    endtask

    task automatic xfer(input int nbytes, input int lowc);
        bus_start();
        for (int i = 0; i < nbytes; i++) bus_byte(8'($urandom), lowc);
        bus_stop(lowc);
    endtask

    task automatic hold_low(input int ticks);
        scl = 1'b0; waitc(ticks * PRE);
        scl = 1'b1; waitc(10);
    endtask

    task automatic mid_frame(input int k);
        bus_start();
        for (int i = 0; i < k; i++) bus_bit((i == k - 1) ? 1'b0 : 1'($urandom), 10);
        sda = 1'b1; waitc(HIGHC);
    endtask

    task automatic clear_all();
        clr = 4'hF; waitc(1);
        clr = 4'h0; waitc(4);
    endtask

    task automatic sample_clear(input string req, input logic [3:0] exp);
        waitc(10);
        check(req, flags, exp);
        clear_all();
    endtask

    initial begin
        void'($urandom(32'h5EED));
        waitc(5);
        rst_n = 1'b1;
        waitc(2);
        check("R9 flags after reset", flags, 4'b0000);
        check("R9 irq after reset", {3'b0, irq}, 4'b0000);

        // R10: one-cycle SDA dip while SCL high would be START then STOP
        sda = 1'b0; waitc(1); sda = 1'b1; waitc(20);
        check("R10 glitch ignored", flags, 4'b0000);

        xfer(2, 10);
        sample_clear("R4 legal START/STOP", 4'b0000);

        hold_low(TLOW - 3);
        check("R1 low below limit", flags, exp_hold(TLOW - 3));
        hold_low(TLOW + 3);
        check("R1 low above limit", flags, exp_hold(TLOW + 3));
        check("R7 irq with flag", {3'b0, irq}, 4'b0001);
        waitc(200);
        check("R6 flag held", flags, 4'b0001);

        mid_frame(4);
        waitc(10);
        check("R4 STOP inside frame", flags, 4'b1001);
        clr = 4'b0001; waitc(1); clr = 4'b0; waitc(4);
        check("R6 single-bit clear", flags, 4'b1000);
        check("R7 irq with remaining flag", {3'b0, irq}, 4'b0001);
        clear_all();
        check("R7 irq after clear", {3'b0, irq}, 4'b0000);

        xfer(1, 12);
        sample_clear("R8 clean transfer after error", 4'b0000);

        xfer(1, 20);
        sample_clear("R3 long segment", exp_xfer(1, 20));
        xfer(3, 14);
        sample_clear("R3 segment restarts at ACK", exp_xfer(3, 14));
        xfer(6, 14);
        sample_clear("R2 transfer total over limit", exp_xfer(6, 14));

        // START in acknowledge slot
        bus_start();
        for (int i = 0; i < 8; i++) bus_bit(1'($urandom), 10);
        bus_bit(1'b1, 10);
        sda = 1'b0; waitc(HIGHC);
        sda = 1'b1; waitc(HIGHC);
        sample_clear("R4 START in ACK slot", 4'b1000);

        // repeated START on first pulse after ACK
        bus_start();
        bus_byte(8'hA6, 10);
        scl = 1'b0; waitc(5); sda = 1'b1; waitc(5);
        scl = 1'b1; waitc(HIGHC); sda = 1'b0; waitc(HIGHC);
        bus_byte(8'h3C, 10);
        bus_stop(10);
        sample_clear("R4 repeated START legal", 4'b0000);

        // STOP on idle bus
        scl = 1'b0; waitc(6); sda = 1'b0; waitc(6);
        scl = 1'b1; waitc(HIGHC); sda = 1'b1; waitc(HIGHC);
        sample_clear("R5 STOP while idle", 4'b0000);

        for (int it = 0; it < 24; it++) begin
            int kind;
            kind = int'($urandom % 3);
            if (kind == 0) begin
                int nb, lc;
                nb = 1 + int'($urandom % 3);
                lc = 8 + int'($urandom % 5);
                xfer(nb, lc);
                sample_clear("R2 R3 random transfer", exp_xfer(nb, lc));
            end else if (kind == 1) begin
                int t;
                t = ($urandom % 2 == 0) ? TLOW + 3 + int'($urandom % 8)
                                        : TLOW - 3 - int'($urandom % 8);
                hold_low(t);
                sample_clear("R1 random low period", exp_hold(t));
            end else begin
                int k;
                k = 2 + int'($urandom % 7);
                mid_frame(k);
                sample_clear("R4 random misplaced STOP", 4'b1000);
            end
        end

        report();
    end
endmodule